// File: doc/BRIEF.md
# Multi-Channel Attenuation Latch Controller

This block keeps the digital volume codes for an eight-channel audio converter path arranged as four left/right pairs. Software-style register writes arrive as an address, a 9-bit data word and a one-cycle write strobe. Each channel has two storage stages: a staging latch that collects new codes quietly, and an active latch whose value drives the channel's attenuation output. Bit 8 of an attenuation write is a commit flag. When it is set, every channel moves its staged code to its active latch on the same clock edge, so a multi-channel volume change lands in one step.

A broadcast address stages one code into all eight channels at once. Two control bits add optional behaviour. The first makes a committed change wait on each channel until that channel's audio sample crosses zero, which avoids audible steps. The second makes each right channel follow its left partner's active code. Converting codes into linear gain happens downstream of this block.

Top module: `att_latch_ctrl`

## Requirements
- R1: After reset every channel's attenuation output is 0xFF (0 dB; the code counts 0.5 dB steps), and the control register is 0, so both optional modes are off.
- R2: Addresses 0..7 select channels; channel 2k is the left member and channel 2k+1 the right member of pair k. Data bits [7:0] carry the code. With bit 8 clear, the code enters only that channel's staging latch and no output changes.
- R3: With bit 8 set and zero-cross mode off, the written code is staged, and on that same edge every channel copies its staged code into its active latch. The outputs show the new codes from the cycle after the write.
- R4: Address 8 stages the written code into all eight channels. Bit 8 commits the same way as in a per-channel write.
- R5: Address 9 is the control register: bit 0 enables zero-cross mode and bit 1 enables pair-follow mode. A write there never commits, even with bit 8 set. A write to any address from 10 to 31 changes neither the outputs nor any staged code. Bit 8 itself is never stored.
- R6: While bit 1 of the control register is set, output channel 2k+1 shows the active code of channel 2k. When the bit is cleared, the right channel shows its own active code again.
- R7: With zero-cross mode on, a commit places each channel's target code in a pending slot and leaves its active code unchanged.
- R8: A channel crossing zero is a sample-valid strobe on that channel whose sample is exactly 0, or whose sign differs from the sign of that channel's previous valid sample (taken as non-negative after reset). On that edge the pending code becomes active.
- R9: A commit that arrives while a change is still pending replaces the pending code. Only the newest code is applied at the next crossing.
- R10: If zero-cross mode is switched off while a change is pending, the pending code becomes active on the next edge after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | 5 | Register address |
| wr_data_i | input | 9 | Bits [7:0] code or control bits, bit 8 commit flag |
| smp_vld_i | input | 8 | Per-channel sample-valid strobe |
| smp_i | input | 128 | Per-channel signed 16-bit samples, channel c in bits [16c+15:16c] |
| att_o | output | 64 | Per-channel effective attenuation code, channel c in bits [8c+7:8c] |

## Verification
Every write and every sample strobe is captured on a rising edge, and its effect on the attenuation outputs is due right after that same edge. This holds for a commit, for release at a zero crossing, and for the pair-follow selection, which reads the freshly written control register. The one exception is a pending code released by switching zero-cross mode off: it becomes visible one edge later, after the control write has landed. The driver posts the full expected output vector tagged with its due edge. The monitor compares it on the falling edge after that edge, well clear of any active edge.

// File: rtl/att_latch_pkg.sv
package att_latch_pkg;
  localparam int unsigned NUM_PAIRS_DEF = 4;
  localparam int unsigned CODE_W_DEF    = 8;
  localparam int unsigned SMP_W_DEF     = 16;
  localparam int unsigned ADDR_W_DEF    = 5;

  typedef struct packed {
    logic pair_follow;
    logic zc_en;
  } ctrl_t;
endpackage

// File: rtl/att_zc_det.sv
module att_zc_det #(
  parameter int unsigned SMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             hit_o
);
  logic sign_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sign_q <= 1'b0;
    else if (vld_i) sign_q <= smp_i[SMP_W-1];
  end

  assign hit_o = vld_i && ((smp_i == '0) || (smp_i[SMP_W-1] != sign_q));
endmodule

// File: rtl/att_chan.sv
module att_chan #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [CODE_W-1:0] ld_val_i,
  input  logic              commit_i,
  input  logic              zc_en_i,
  input  logic              zc_hit_i,
  output logic [CODE_W-1:0] act_o,
  output logic              pend_o
);
  logic [CODE_W-1:0] stage_q, pend_q, act_q, tgt;
  logic              pend_vld_q;

  // a write in the commit cycle supplies its own channel's target directly
  assign tgt = ld_i ? ld_val_i : stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q    <= '1;
      pend_q     <= '1;
      act_q      <= '1;
      pend_vld_q <= 1'b0;
    end else begin
      if (ld_i) stage_q <= ld_val_i;
      if (commit_i) begin
        if (zc_en_i) begin
          pend_q     <= tgt;
          pend_vld_q <= 1'b1;
        end else begin
          act_q      <= tgt;
          pend_vld_q <= 1'b0;
        end
      end else if (pend_vld_q && (!zc_en_i || zc_hit_i)) begin
        act_q      <= pend_q;
        pend_vld_q <= 1'b0;
      end
    end
  end

  assign act_o  = act_q;
  assign pend_o = pend_vld_q;
endmodule

// File: rtl/att_latch_ctrl.sv
module att_latch_ctrl
  import att_latch_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = NUM_PAIRS_DEF,
  parameter int unsigned CODE_W    = CODE_W_DEF,
  parameter int unsigned SMP_W     = SMP_W_DEF,
  parameter int unsigned ADDR_W    = ADDR_W_DEF
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [CODE_W:0]               wr_data_i,
  input  logic [2*NUM_PAIRS-1:0]        smp_vld_i,
  input  logic [2*NUM_PAIRS*SMP_W-1:0]  smp_i,
  output logic [2*NUM_PAIRS*CODE_W-1:0] att_o
);
  localparam int unsigned NCH = 2 * NUM_PAIRS;
  localparam logic [ADDR_W-1:0] MAST_ADDR = ADDR_W'(NCH);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NCH + 1);

  ctrl_t                   ctrl_q;
  logic                    zc_en, commit, chan_wr, mast_wr, ctrl_wr;
  logic [NCH-1:0]          ld, zc_hit, pend_vld;
  logic [NCH*CODE_W-1:0]   act_flat;

  assign chan_wr = wr_en_i && (wr_addr_i < MAST_ADDR);
  assign mast_wr = wr_en_i && (wr_addr_i == MAST_ADDR);
  assign ctrl_wr = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign commit  = (chan_wr || mast_wr) && wr_data_i[CODE_W];
  assign zc_en   = ctrl_q.zc_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data_i[1:0]);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign ld[c] = mast_wr || (chan_wr && (wr_addr_i == ADDR_W'(c)));

    att_zc_det #(.SMP_W(SMP_W)) u_zc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (smp_vld_i[c]),
      .smp_i  (smp_i[c*SMP_W +: SMP_W]),
      .hit_o  (zc_hit[c])
    );

    att_chan #(.CODE_W(CODE_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (ld[c]),
      .ld_val_i (wr_data_i[CODE_W-1:0]),
      .commit_i (commit),
      .zc_en_i  (zc_en),
      .zc_hit_i (zc_hit[c]),
      .act_o    (act_flat[c*CODE_W +: CODE_W]),
      .pend_o   (pend_vld[c])
    );
  end

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    assign att_o[2*k*CODE_W +: CODE_W]     = act_flat[2*k*CODE_W +: CODE_W];
    assign att_o[(2*k+1)*CODE_W +: CODE_W] = ctrl_q.pair_follow ?
                                             act_flat[2*k*CODE_W +: CODE_W] :
                                             act_flat[(2*k+1)*CODE_W +: CODE_W];
  end
endmodule

module att_latch_ctrl_chk #(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned ADDR_W    = 5
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic [ADDR_W-1:0]             wr_addr_i,
  input logic [CODE_W:0]               wr_data_i,
  input logic [2*NUM_PAIRS*CODE_W-1:0] act_flat,
  input logic [2*NUM_PAIRS-1:0]        pend_vld,
  input logic [2*NUM_PAIRS-1:0]        zc_hit,
  input logic                          commit,
  input logic                          zc_en
);
  localparam int unsigned NCH = 2 * NUM_PAIRS;
  localparam logic [ADDR_W-1:0] MAST_ADDR = ADDR_W'(NCH);

  assert_stage_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i < MAST_ADDR && !wr_data_i[CODE_W] && pend_vld == '0)
    |=> $stable(act_flat));

  for (genvar c = 0; c < NCH; c++) begin : g_a
    assert_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == ADDR_W'(c) && wr_data_i[CODE_W] && !zc_en)
      |=> act_flat[c*CODE_W +: CODE_W] == $past(wr_data_i[CODE_W-1:0]));
  end

  assert_master_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == MAST_ADDR && wr_data_i[CODE_W] && !zc_en)
    |=> act_flat == {NCH{$past(wr_data_i[CODE_W-1:0])}});

  assert_defer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && zc_en) |=> $stable(act_flat));

  assert_wait_cross_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit && zc_en && zc_hit == '0) |=> $stable(act_flat));
endmodule

bind att_latch_ctrl att_latch_ctrl_chk #(
  .NUM_PAIRS (NUM_PAIRS),
  .CODE_W    (CODE_W),
  .ADDR_W    (ADDR_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .act_flat  (act_flat),
  .pend_vld  (pend_vld),
  .zc_hit    (zc_hit),
  .commit    (commit),
  .zc_en     (zc_en)
);

// File: tb/att_latch_ctrl_tb.sv
`timescale 1ns/1ps
module att_latch_ctrl_tb_top;
  localparam int NCH = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [4:0]      wr_addr = '0;
  logic [8:0]      wr_data = '0;
  logic [NCH-1:0]  smp_vld = '0;
  logic [NCH*16-1:0] smp = '0;
  logic [NCH*8-1:0]  att;

  always #4 clk = ~clk;

  att_latch_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .smp_vld_i(smp_vld), .smp_i(smp), .att_o(att)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic [7:0] m_stage [NCH], m_act [NCH], m_pend [NCH];
  bit         m_pv [NCH], m_sign [NCH];
  bit         m_zc = 0, m_pair = 0;

  int          q_due[$];
  logic [63:0] q_exp[$];
  string       q_tag[$];

  always @(posedge clk) cyc++;

  function automatic logic [63:0] model_out();
    logic [63:0] v;
    for (int c = 0; c < NCH; c++)
      v[c*8 +: 8] = (m_pair && c[0]) ? m_act[c-1] : m_act[c];
    return v;
  endfunction

  task automatic check(input string tag, input logic [63:0] a, input logic [63:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, a, e);
    end
  endtask

  // monitor: compares every posted item on the falling edge after its due edge
  initial forever begin
    @(negedge clk);
    while (q_due.size() > 0 && q_due[0] == cyc) begin
      check(q_tag[0], att, q_exp[0]);
      void'(q_due.pop_front()); void'(q_exp.pop_front()); void'(q_tag.pop_front());
    end
  end

  // driver: one cycle of stimulus, reference update, expected item posted
  task automatic op(input string tag, input bit we, input logic [4:0] a,
                    input logic [8:0] d, input logic [NCH-1:0] vm, input logic [15:0] s);
    bit hit [NCH];
    bit cm;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; smp_vld = vm;
    for (int c = 0; c < NCH; c++) smp[c*16 +: 16] = s;
    cm = we && (a <= 5'd8) && d[8];
    for (int c = 0; c < NCH; c++) begin
      bit ld;
      logic [7:0] tgt;
      hit[c] = vm[c] && (s == 16'd0 || s[15] != m_sign[c]);
      ld  = we && (a == 5'(c) || a == 5'd8);
      tgt = ld ? d[7:0] : m_stage[c];
      if (cm) begin
        if (m_zc) begin m_pend[c] = tgt; m_pv[c] = 1; end
        else begin m_act[c] = tgt; m_pv[c] = 0; end
      end else if (m_pv[c] && (!m_zc || hit[c])) begin
        m_act[c] = m_pend[c]; m_pv[c] = 0;
      end
      if (ld) m_stage[c] = d[7:0];
      if (vm[c]) m_sign[c] = s[15];
    end
    if (we && a == 5'd9) begin m_zc = d[0]; m_pair = d[1]; end
    q_due.push_back(cyc + 1); q_exp.push_back(model_out()); q_tag.push_back(tag);
  endtask

  task automatic wr(input string tag, input logic [4:0] a, input logic [8:0] d);
    op(tag, 1'b1, a, d, '0, 16'd0);
  endtask

  task automatic smpl(input string tag, input logic [NCH-1:0] vm, input logic [15:0] s);
    op(tag, 1'b0, 5'd0, 9'd0, vm, s);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_stage[c] = 8'hFF; m_act[c] = 8'hFF; m_pend[c] = 8'hFF; m_pv[c] = 0; m_sign[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs 0xFF", att, {NCH{8'hFF}});

    wr("R2 stage ch0 only", 5'd0, 9'h040);
    wr("R2 stage ch3 only", 5'd3, 9'h022);
    wr("R3 commit all via ch5", 5'd5, 9'h110);
    wr("R4 master stage", 5'd8, 9'h080);
    wr("R4 ch1 commit after master stage", 5'd1, 9'h133);
    wr("R4 master commit", 5'd8, 9'h105);

    wr("R6 pair follow on", 5'd9, 9'h002);
    wr("R6 left change seen on right", 5'd0, 9'h111);
    wr("R6 pair follow off", 5'd9, 9'h000);

    wr("R5 ignored addr 15", 5'd15, 9'h1AA);
    wr("R5 ignored addr 31", 5'd31, 9'h0BB);
    wr("R5 ctrl write does not commit", 5'd9, 9'h100);
    wr("R5 commit shows no stray staging", 5'd7, 9'h177);

    wr("R7 zc mode on", 5'd9, 9'h001);
    wr("R7 commit held pending", 5'd2, 9'h160);
    smpl("R8 same sign no crossing", 8'h04, 16'd100);
    smpl("R8 other channel negative irrelevant", 8'h01, 16'hFFF0);
    smpl("R8 sign change releases ch2", 8'h04, 16'hFFFB);
    wr("R8 commit from negative side", 5'd2, 9'h161);
    smpl("R8 positive after negative releases", 8'h04, 16'd3);

    wr("R9 first pending ch4", 5'd4, 9'h170);
    wr("R9 replacement pending ch4", 5'd4, 9'h171);
    smpl("R9 zero sample applies newest", 8'h10, 16'd0);

    wr("R10 pending ch6", 5'd6, 9'h144);
    wr("R10 zc mode off", 5'd9, 9'h000);
    op("R10 released after mode off", 1'b0, 5'd0, 9'd0, '0, 16'd0);
    wr("R3 direct commit after zc off", 5'd6, 9'h1C0);

    repeat (3) @(negedge clk);
    if (q_due.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard not drained act=%0d exp=0", q_due.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule